// File: doc/BRIEF.md
# Packet Stream Control-Word Checker

This block watches the receive-side word stream of a packet interface, one 16-bit word per clock, in which each word is marked either as a control word or as a data word. It sorts each control word by kind: payload control, idle, or training. It also follows the packet and burst sequence. Any protocol violation is reported on a status vector, together with a combined error flag.

Control words are often sent more than once in a row. The block turns each such run into a single clean event for the downstream framing logic. In a run of consecutive payload control words, the last one is the one that counts: its address and start-of-packet bit are reported once, when the burst actually starts. In a run of consecutive control words that carry an end-of-packet indication, only the first one counts. Parity checking, training-pattern detection and clock-domain crossing are handled elsewhere.

Every output is registered. A word presented at a rising edge shows its effect on the outputs immediately after that edge.

Top module: `ctlword_checker`

## Requirements
- R1: With `ctrl_i`=1 the word is a control word. Bit 15=1 marks a payload control and bit 15=0 marks an idle or training control. Bits 14:13 carry the end code: 00 none, 01 end with two bytes valid, 10 end with one byte valid, 11 reserved. Bit 12 is start-of-packet, bits 11:4 are the channel address, and bits 3:0 play no part in any decision except the training-word match.
- R2: `stat_o[7:6]` are always 0. `err_o` is high in exactly the cycles in which any `stat_o` bit is high.
- R3: `stat_o[5]` pulses for an idle or training control with a non-zero address field, except for the training word 0x0FFF.
- R4: `stat_o[4]` pulses for any control word with end code 11.
- R5: `stat_o[3]` pulses for an idle or training control that directly follows a payload control.
- R6: `stat_o[2]` pulses for a data word that does not fall inside both an open burst and an open packet. A burst opens at a payload control and closes at an idle or training control.
- R7: `stat_o[1]` pulses when an end indication that takes effect finds no packet open.
- R8: `stat_o[0]` pulses when the kept payload control of a run has start-of-packet set while a packet is still open. Within one word, an end indication closes the previous packet before the same word's start-of-packet is considered.
- R9: In a run of back-to-back payload controls only the last is kept. `pay_start_o` pulses for one cycle after the first following word that is not a payload control, and `pay_addr_o` and `pay_sop_o` then carry the kept word's address and start bit.
- R10: In a run of back-to-back control words with end code 01 or 10, only the first takes effect. `pkt_end_o` pulses for it if a packet is open, and `end_one_o` is high when its code is 10. The later words in the run produce neither an end pulse nor an error.
- R11: Each status bit pulses for one cycle, in the cycle after the offending word's edge. Reset clears all outputs and leaves no packet, burst or pending control open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 1 | 1 marks `word_i` as a control word |
| word_i | input | 16 | Received word |
| stat_o | output | 8 | Error status vector, one bit per violation kind |
| err_o | output | 1 | Combined error flag |
| pay_start_o | output | 1 | One-cycle pulse: a kept payload control has begun its burst |
| pay_sop_o | output | 1 | Start-of-packet bit of the kept payload control |
| pay_addr_o | output | 8 | Channel address of the kept payload control |
| pkt_end_o | output | 1 | One-cycle pulse: an end of packet took effect |
| end_one_o | output | 1 | With `pkt_end_o`: only one byte of the last word is valid |

## Verification
The bench builds the block with its default parameters: a 16-bit word, an 8-bit address and an 8-bit status vector. With these values every field position named in R1 and the training word 0x0FFF can be driven literally. A single vector walk takes the block through three-deep redundant payload runs, doubled end indications, a word that raises three status bits at once, and a burst opened without a packet. Directed steps then check the reset state, and check that a reset in the middle of a packet leaves nothing open.

// File: rtl/ctlchk_pkg.sv
package ctlchk_pkg;

   // End code carried by every control word
   typedef enum logic [1:0] {
      END_NONE = 2'b00,
      END_TWO  = 2'b01,
      END_ONE  = 2'b10,
      END_RSV  = 2'b11
   } end_code_e;

   // Classification of one received word
   typedef struct packed {
      logic pay;       // payload control word
      logic nonpay;    // idle or training control word
      logic data;      // data word
      logic sop;       // start-of-packet bit of a control word
      logic end_ok;    // valid end indication
      logic end_one;   // end with one byte valid
      logic end_rsv;   // reserved end code
      logic addr_bad;  // non-payload control with non-zero address
   } word_cls_t;

   // Status vector bit positions
   localparam int unsigned ST_SOP_OPEN  = 0;
   localparam int unsigned ST_END_IDLE  = 1;
   localparam int unsigned ST_DATA_OUT  = 2;
   localparam int unsigned ST_IDLE_EARLY = 3;
   localparam int unsigned ST_END_RSV   = 4;
   localparam int unsigned ST_ADDR_BAD  = 5;
   localparam int unsigned ST_NUM_FLAGS = 6;

endpackage

// File: rtl/ctlchk_decode.sv
module ctlchk_decode
   import ctlchk_pkg::*;
#(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned CHK_W  = 4,
   parameter logic [WORD_W-1:0] TRAIN_WORD = 16'h0FFF
) (
   input  logic              ctrl_i,
   input  logic [WORD_W-1:0] word_i,
   output word_cls_t         cls_o,
   output logic [ADDR_W-1:0] addr_o
);

   localparam int unsigned TYPE_BIT = WORD_W - 1;
   localparam int unsigned END_HI   = WORD_W - 2;
   localparam int unsigned END_LO   = WORD_W - 3;
   localparam int unsigned SOP_BIT  = WORD_W - 4;
   localparam int unsigned ADDR_LO  = CHK_W;

   end_code_e end_code;
   logic      is_train;

   assign addr_o = word_i[ADDR_LO +: ADDR_W];

   always_comb begin
      end_code       = end_code_e'(word_i[END_HI:END_LO]);
      cls_o          = '0;
      cls_o.data     = ~ctrl_i;
      cls_o.pay      = ctrl_i & word_i[TYPE_BIT];
      cls_o.nonpay   = ctrl_i & ~word_i[TYPE_BIT];
      cls_o.sop      = ctrl_i & word_i[SOP_BIT];
      is_train       = cls_o.nonpay & (word_i == TRAIN_WORD);
      cls_o.end_ok   = ctrl_i & ((end_code == END_TWO) | (end_code == END_ONE));
      cls_o.end_one  = ctrl_i & (end_code == END_ONE);
      cls_o.end_rsv  = ctrl_i & (end_code == END_RSV);
      cls_o.addr_bad = cls_o.nonpay & (|addr_o) & ~is_train;
   end

endmodule

// File: rtl/ctlchk_seq.sv
module ctlchk_seq
   import ctlchk_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned STAT_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  word_cls_t         cls_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [STAT_W-1:0] stat_o,
   output logic              err_o,
   output logic              pay_start_o,
   output logic              pay_sop_o,
   output logic [ADDR_W-1:0] pay_addr_o,
   output logic              pkt_end_o,
   output logic              end_one_o
);

   // Sequencing state
   logic              in_pkt_q;
   logic              pend_q;
   logic              pend_sop_q;
   logic [ADDR_W-1:0] pend_addr_q;
   logic              prev_end_q;
   logic              burst_q;

   // Per-word decisions
   logic resolve, open_mid, open_next, end_take, end_fire;
   logic [ST_NUM_FLAGS-1:0] flags;
   logic [STAT_W-1:0]       stat_d;

   always_comb begin
      // A pending payload control is kept once a non-payload word follows
      resolve   = pend_q & ~cls_i.pay;
      // Kept start-of-packet applies before this word's end indication
      open_mid  = in_pkt_q | (resolve & pend_sop_q);
      // Only the first of consecutive end indications counts
      end_take  = cls_i.end_ok & ~prev_end_q;
      end_fire  = end_take & open_mid;
      open_next = open_mid & ~end_take;

      flags                = '0;
      flags[ST_SOP_OPEN]   = resolve & pend_sop_q & in_pkt_q;
      flags[ST_END_IDLE]   = end_take & ~open_mid;
      flags[ST_DATA_OUT]   = cls_i.data & ~((pend_q | burst_q) & open_mid);
      flags[ST_IDLE_EARLY] = cls_i.nonpay & pend_q;
      flags[ST_END_RSV]    = cls_i.end_rsv;
      flags[ST_ADDR_BAD]   = cls_i.addr_bad;
   end

   // Status vector: live flags low, reserved bits tied low
   assign stat_d[ST_NUM_FLAGS-1:0] = flags;
   for (genvar gi = ST_NUM_FLAGS; gi < STAT_W; gi++) begin : g_rsv
      assign stat_d[gi] = 1'b0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         in_pkt_q    <= 1'b0;
         pend_q      <= 1'b0;
         pend_sop_q  <= 1'b0;
         pend_addr_q <= '0;
         prev_end_q  <= 1'b0;
         burst_q     <= 1'b0;
      end else begin
         in_pkt_q   <= open_next;
         pend_q     <= cls_i.pay;
         prev_end_q <= cls_i.end_ok;
         burst_q    <= cls_i.data & (pend_q | burst_q);
         if (cls_i.pay) begin
            pend_sop_q  <= cls_i.sop;
            pend_addr_q <= addr_i;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stat_o      <= '0;
         err_o       <= 1'b0;
         pay_start_o <= 1'b0;
         pay_sop_o   <= 1'b0;
         pay_addr_o  <= '0;
         pkt_end_o   <= 1'b0;
         end_one_o   <= 1'b0;
      end else begin
         stat_o      <= stat_d;
         err_o       <= |flags;
         pay_start_o <= resolve;
         pkt_end_o   <= end_fire;
         end_one_o   <= end_fire & cls_i.end_one;
         if (resolve) begin
            pay_sop_o  <= pend_sop_q;
            pay_addr_o <= pend_addr_q;
         end
      end
   end

   // R10: the first of consecutive end indications wins, so no two end pulses touch
   a_r10_end_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pkt_end_o |=> !pkt_end_o);

   // R9: a kept payload control starts its burst exactly once
   a_r9_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pay_start_o |=> !pay_start_o);

   // R2: the combined flag never rises without a status bit
   a_r2_flag_with_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |-> (|stat_o));

   // R8: a start-inside-open-packet error needs a pending payload control
   a_r8_sop_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stat_o[ST_SOP_OPEN] |-> pay_start_o);

endmodule

// File: rtl/ctlword_checker.sv
module ctlword_checker
   import ctlchk_pkg::*;
#(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned CHK_W  = 4,
   parameter int unsigned STAT_W = 8,
   parameter logic [WORD_W-1:0] TRAIN_WORD = 16'h0FFF
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ctrl_i,
   input  logic [WORD_W-1:0] word_i,
   output logic [STAT_W-1:0] stat_o,
   output logic              err_o,
   output logic              pay_start_o,
   output logic              pay_sop_o,
   output logic [ADDR_W-1:0] pay_addr_o,
   output logic              pkt_end_o,
   output logic              end_one_o
);

   localparam int unsigned FIELD_SUM = 4 + ADDR_W + CHK_W;
   localparam int unsigned END_HI    = WORD_W - 2;
   localparam int unsigned END_LO    = WORD_W - 3;

   // Elaboration-time parameter checks
   if (FIELD_SUM != WORD_W) begin : g_bad_layout
      $error("word width must equal 4 + address width + check width");
   end
   if (STAT_W < ST_NUM_FLAGS) begin : g_bad_stat
      $error("status vector narrower than the number of error kinds");
   end

   word_cls_t         cls;
   logic [ADDR_W-1:0] addr;

   ctlchk_decode #(
      .WORD_W    (WORD_W),
      .ADDR_W    (ADDR_W),
      .CHK_W     (CHK_W),
      .TRAIN_WORD(TRAIN_WORD)
   ) u_decode (
      .ctrl_i (ctrl_i),
      .word_i (word_i),
      .cls_o  (cls),
      .addr_o (addr)
   );

   ctlchk_seq #(
      .ADDR_W (ADDR_W),
      .STAT_W (STAT_W)
   ) u_seq (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cls_i       (cls),
      .addr_i      (addr),
      .stat_o      (stat_o),
      .err_o       (err_o),
      .pay_start_o (pay_start_o),
      .pay_sop_o   (pay_sop_o),
      .pay_addr_o  (pay_addr_o),
      .pkt_end_o   (pkt_end_o),
      .end_one_o   (end_one_o)
   );

   // R3: address error only after a non-training idle control word
   a_r3_addr_flag_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stat_o[ST_ADDR_BAD] |-> $past(ctrl_i && !word_i[WORD_W-1] && (word_i != TRAIN_WORD)));

   // R4: reserved end code flag follows a control word carrying code 11
   a_r4_rsv_flag_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stat_o[ST_END_RSV] |-> $past(ctrl_i && (word_i[END_HI:END_LO] == 2'b11)));

   // R6: data-outside-packet flag only ever follows a data word
   a_r6_data_flag_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stat_o[ST_DATA_OUT] |-> $past(!ctrl_i));

   // R10: an end pulse follows a control word with a valid end code
   a_r10_end_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pkt_end_o |-> $past(ctrl_i && (word_i[END_HI:END_LO] != 2'b00)
                          && (word_i[END_HI:END_LO] != 2'b11)));

endmodule

// File: tb/ctlword_checker_tb_top.sv
module ctlword_checker_tb_top;

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        ctrl_i = 1'b0;
   logic [15:0] word_i = '0;
   logic [7:0]  stat_o;
   logic        err_o, pay_start_o, pay_sop_o, pkt_end_o, end_one_o;
   logic [7:0]  pay_addr_o;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #5 clk_i = ~clk_i;

   ctlword_checker dut_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_i(ctrl_i), .word_i(word_i),
      .stat_o(stat_o), .err_o(err_o), .pay_start_o(pay_start_o),
      .pay_sop_o(pay_sop_o), .pay_addr_o(pay_addr_o),
      .pkt_end_o(pkt_end_o), .end_one_o(end_one_o)
   );

   // Entry: {ctrl, word, stat, start, sop, addr, end, one}
   localparam int NV = 22;
   localparam logic [36:0] VEC [NV] = '{
      {1'b1, 16'h9120, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
      {1'b0, 16'hAAAA, 8'h00, 1'b1, 1'b1, 8'h12, 1'b0, 1'b0},
      {1'b0, 16'h5555, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
      {1'b1, 16'hB340, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0},
      {1'b1, 16'hC560, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
      {1'b1, 16'h9780, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
      {1'b0, 16'h1234, 8'h00, 1'b1, 1'b1, 8'h78, 1'b0, 1'b0},
      {1'b1, 16'h0000, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
      {1'b0, 16'hBEEF, 8'h04, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
      {1'b1, 16'h99A0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
      {1'b1, 16'h6000, 8'h19, 1'b1, 1'b1, 8'h9A, 1'b0, 1'b0},
      {1'b1, 16'h4000, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1},
      {1'b1, 16'h2000, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
      {1'b1, 16'h0050, 8'h20, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
      {1'b1, 16'h0FFF, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
      {1'b1, 16'h2000, 8'h02, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
      {1'b0, 16'h0001, 8'h04, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
      {1'b1, 16'h8110, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
      {1'b0, 16'h0002, 8'h04, 1'b1, 1'b0, 8'h11, 1'b0, 1'b0},
      {1'b1, 16'h9220, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
      {1'b1, 16'h0FFF, 8'h08, 1'b1, 1'b1, 8'h22, 1'b0, 1'b0},
      {1'b1, 16'h2000, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Drive one word away from the edge, then sample just after the capturing edge
   task automatic send(input logic c, input logic [15:0] w);
      @(negedge clk_i);
      ctrl_i = c;
      word_i = w;
      @(posedge clk_i);
      #2;
   endtask

   task automatic check_quiet(input string tag);
      check(tag, {stat_o, err_o, pay_start_o, pkt_end_o, end_one_o}, '0);
   endtask

   initial begin
      repeat (3) @(posedge clk_i);
      #2;
      check_quiet("R11 reset outputs");
      @(negedge clk_i);
      rst_ni = 1'b1;

      // Vector walk: R1 layout, R3..R8 status, R2 flag, R9 start, R10 end
      for (int i = 0; i < NV; i++) begin
         send(VEC[i][36], VEC[i][35:20]);
         check("R1 R3 R4 R5 R6 R7 R8 status", stat_o, VEC[i][19:12]);
         check("R2 combined flag", err_o, |VEC[i][19:12]);
         check("R9 payload start", pay_start_o, VEC[i][11]);
         if (VEC[i][11]) begin
            check("R9 kept sop", pay_sop_o, VEC[i][10]);
            check("R9 kept address", pay_addr_o, VEC[i][9:2]);
         end
         check("R10 packet end", pkt_end_o, VEC[i][1]);
         check("R10 one-byte end", end_one_o, VEC[i][0]);
      end

      // R11: pulses last one cycle; an idle word after an error is quiet
      send(1'b1, 16'h0000);
      check_quiet("R11 single-cycle pulse");

      // R11: reset in the middle of an open packet clears everything
      send(1'b1, 16'h9120);
      send(1'b0, 16'hAAAA);
      check("R9 start before reset", pay_start_o, 1'b1);
      @(negedge clk_i);
      rst_ni = 1'b0;
      #2;
      check_quiet("R11 async reset outputs");
      @(negedge clk_i);
      rst_ni = 1'b1;
      send(1'b0, 16'h3333);
      check("R11 R6 no burst after reset", stat_o, 8'h04);
      send(1'b1, 16'h2000);
      check("R11 R7 no packet after reset", stat_o, 8'h02);
      check("R10 no end after reset", pkt_end_o, 1'b0);

      // R3: training word is exempt, any other idle with an address is not
      send(1'b1, 16'h0FF0);
      check("R3 non-training address", stat_o, 8'h20);
      check("R2 flag on address error", err_o, 1'b1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk_i);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL R11 watchdog actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule